// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Short-Circuit Blanking Controller

This block drives the two gate enables of one half-bridge phase. A controller supplies a high-side and a low-side on command. The block turns those commands into gate enables that are never on together. Before any switch turns on, both switches must have been off for a programmable number of clock cycles, whatever the timing of the commands. The dead-time length is a cycle count on an input port, so a 100 MHz clock covers a range from tens of nanoseconds to several microseconds.

Each time a switch turns on, a blanking counter starts. Because a switch can only turn on once the dead time has elapsed, this counter starts at the end of the dead time. While it runs, the drain-source overvoltage flag for that side is ignored. Once it expires, the flag is checked on every cycle that the switch stays on, and a flag that is still high sets a sticky short-circuit fault for that side. For the high side, an optional check also reports a fault if the switch node has not risen above its fixed level once blanking ends.

A bootstrap undervoltage flag removes the high-side gate. The gate stays off until the high-side command shows a fresh rising edge, and this event raises no fault. A global disable forces both gates off, and the dead-time count starts again when the disable is released.

Top module: `phase_gate_ctrl`

## Requirements
- R1: The two gate outputs are never high in the same cycle. While both commands are high, both gates are low from the next cycle onward.
- R2: A gate rises only after both gates have been low for at least `dt_cycles`+1 consecutive cycles. When a command is handed from one side to the other, the gap is exactly `dt_cycles`+1 cycles.
- R3: While `drv_disable` is high, both gates are low from the next cycle. After release, with a command held, the gate rises after exactly `dt_cycles` further low samples, because the dead-time count restarts at release.
- R4: A gate falls in the cycle after its command goes low, with no added delay.
- R5: The blanking length is 300 cycles when `blank_short` is 0 and 273 cycles when it is 1. Counting begins at the cycle the gate rises, so a flag held high sets the fault on the sample at index length+1, where index 0 is the first sample with the gate high.
- R6: A VDS flag that is high during blanking does not set the fault of that side.
- R7: A VDS flag that is high on any cycle after blanking, while that gate is still on, sets that side's fault. The fault stays set until reset.
- R8: With `node_chk_en` at 1, a low `sw_node_hi` after high-side blanking sets `fault_hs`. With `node_chk_en` at 0, `sw_node_hi` has no effect.
- R9: `bst_uv` drops the high-side gate in the next cycle without setting `fault_hs`. The gate stays off while the command is held, and it returns only after a new rising edge of `hs_cmd`.
- R10: After reset, both gates and both faults are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_disable | input | 1 | Forces both gates off and restarts the dead-time count |
| hs_cmd | input | 1 | High-side on command |
| ls_cmd | input | 1 | Low-side on command |
| dt_cycles | input | DT_W | Dead time in clock cycles |
| blank_short | input | 1 | Selects the 273-cycle blanking length instead of 300 |
| vds_hs | input | 1 | High-side drain-source overvoltage flag |
| vds_ls | input | 1 | Low-side drain-source overvoltage flag |
| node_chk_en | input | 1 | Enables the high-side switch-node level check |
| sw_node_hi | input | 1 | Switch node is above its fixed level |
| bst_uv | input | 1 | Bootstrap undervoltage flag |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| fault_hs | output | 1 | Sticky high-side short-circuit fault |
| fault_ls | output | 1 | Sticky low-side short-circuit fault |

## Verification
Bootstrap undervoltage removal and short-circuit detection can both act on the high side in the same cycle. Random runs pulse `bst_uv` while `vds_hs` and the node check are active just past blanking, and the cycle-level bench model decides whether the fault was captured before the gate fell. Dead-time arbitration and a disable release can also coincide. Commands are therefore swapped in the same cycle that `drv_disable` drops, and the gate-rise timing is judged against the model's off-cycle count.

// File: rtl/phase_pkg.sv
package phase_pkg;
  typedef enum logic {SIDE_HS = 1'b0, SIDE_LS = 1'b1} side_e;

  // dead time has run out once the idle count reaches the programmed value
  function automatic logic dead_elapsed(input logic [31:0] idle_cnt, input logic [31:0] dt);
    return idle_cnt >= dt;
  endfunction

  // blanking length picked by the short-setting select
  function automatic logic [31:0] blank_cycles(input logic short_sel, input logic [31:0] long_c,
                                               input logic [31:0] short_c);
    return short_sel ? short_c : long_c;
  endfunction
endpackage

// File: rtl/bst_guard.sv
module bst_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic bst_uv,
  output logic hs_block
);
  logic blk_q, cmd_q, cmd_rise, blk_eff;

  assign cmd_rise = hs_cmd & ~cmd_q;
  assign blk_eff  = blk_q & ~cmd_rise;
  assign hs_block = bst_uv | blk_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      cmd_q <= 1'b0;
    end else begin
      blk_q <= hs_block;
      cmd_q <= hs_cmd;
    end
  end
endmodule

// File: rtl/dt_arbiter.sv
module dt_arbiter #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dis,
  input  logic            req_hs,
  input  logic            req_ls,
  input  logic [DT_W-1:0] dt_cycles,
  output logic            hs_on,
  output logic            ls_on,
  output logic            gap_ok
);
  import phase_pkg::*;
  logic [DT_W-1:0] idle_cnt;
  logic            hs_nx, ls_nx;

  assign gap_ok = ~hs_on & ~ls_on & dead_elapsed(32'(idle_cnt), 32'(dt_cycles));
  assign hs_nx  = hs_on ? req_hs : (gap_ok & req_hs);
  assign ls_nx  = ls_on ? req_ls : (gap_ok & req_ls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_on    <= 1'b0;
      ls_on    <= 1'b0;
      idle_cnt <= '0;
    end else begin
      hs_on <= hs_nx;
      ls_on <= ls_nx;
      if (hs_on | ls_on | dis) idle_cnt <= '0;
      else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/blank_mon.sv
module blank_mon #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_on,
  input  logic [CNT_W-1:0] blank_len,
  input  logic             bad_flag,
  output logic             armed,
  output logic             fault
);
  logic [CNT_W-1:0] on_cnt;

  assign armed = on_cnt >= blank_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt <= '0;
      fault  <= 1'b0;
    end else begin
      if (!gate_on) on_cnt <= '0;
      else if (on_cnt != '1) on_cnt <= on_cnt + 1'b1;
      if (gate_on & armed & bad_flag) fault <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_gate_ctrl.sv
module phase_gate_ctrl #(
  parameter int DT_W        = 10,
  parameter int BLANK_LONG  = 300,
  parameter int BLANK_SHORT = 273
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drv_disable,
  input  logic            hs_cmd,
  input  logic            ls_cmd,
  input  logic [DT_W-1:0] dt_cycles,
  input  logic            blank_short,
  input  logic            vds_hs,
  input  logic            vds_ls,
  input  logic            node_chk_en,
  input  logic            sw_node_hi,
  input  logic            bst_uv,
  output logic            hs_gate,
  output logic            ls_gate,
  output logic            fault_hs,
  output logic            fault_ls
);
  import phase_pkg::*;
  localparam int BLK_MAX = (BLANK_LONG > BLANK_SHORT) ? BLANK_LONG : BLANK_SHORT;
  localparam int BLK_W   = $clog2(BLK_MAX + 1);

  logic             hs_block_w, req_hs_w, req_ls_w, gap_ok_w;
  logic [BLK_W-1:0] blank_len_w;
  logic [1:0]       gate_w, bad_w, armed_w, fault_w;

  bst_guard u_guard (
    .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .bst_uv(bst_uv), .hs_block(hs_block_w)
  );

  assign req_hs_w = hs_cmd & ~ls_cmd & ~drv_disable & ~hs_block_w;
  assign req_ls_w = ls_cmd & ~hs_cmd & ~drv_disable;

  dt_arbiter #(.DT_W(DT_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .dis(drv_disable), .req_hs(req_hs_w), .req_ls(req_ls_w),
    .dt_cycles(dt_cycles), .hs_on(gate_w[SIDE_HS]), .ls_on(gate_w[SIDE_LS]), .gap_ok(gap_ok_w)
  );

  assign blank_len_w  = BLK_W'(blank_cycles(blank_short, 32'(BLANK_LONG), 32'(BLANK_SHORT)));
  assign bad_w[SIDE_HS] = vds_hs | (node_chk_en & ~sw_node_hi);
  assign bad_w[SIDE_LS] = vds_ls;

  for (genvar s = 0; s < 2; s++) begin : g_side
    blank_mon #(.CNT_W(BLK_W)) u_blank (
      .clk(clk), .rst_n(rst_n), .gate_on(gate_w[s]), .blank_len(blank_len_w),
      .bad_flag(bad_w[s]), .armed(armed_w[s]), .fault(fault_w[s])
    );
  end

  assign hs_gate  = gate_w[SIDE_HS];
  assign ls_gate  = gate_w[SIDE_LS];
  assign fault_hs = fault_w[SIDE_HS];
  assign fault_ls = fault_w[SIDE_LS];
endmodule

// File: rtl/phase_gate_chk.sv
module phase_gate_chk #(
  parameter int DT_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            drv_disable,
  input logic            hs_cmd,
  input logic            ls_cmd,
  input logic            bst_uv,
  input logic [DT_W-1:0] dt_cycles,
  input logic            hs_gate,
  input logic            ls_gate,
  input logic            fault_hs,
  input logic            fault_ls,
  input logic [1:0]      armed_w
);
  logic [DT_W:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_run <= '0;
    else if (hs_gate | ls_gate) off_run <= '0;
    else if (off_run != '1) off_run <= off_run + 1'b1;
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n) !(hs_gate && ls_gate));
  p_both_cmd_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_cmd && ls_cmd) |=> (!hs_gate && !ls_gate));
  p_dead_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> (off_run > {1'b0, dt_cycles}));
  p_dead_ls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (off_run > {1'b0, dt_cycles}));
  p_disable_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_disable |=> (!hs_gate && !ls_gate));
  p_cmd_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_cmd |=> !hs_gate);
  p_hs_fault_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_hs) |-> $past(armed_w[0] && hs_gate));
  p_ls_fault_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_ls) |-> $past(armed_w[1] && ls_gate));
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hs || fault_ls) |=> ($past(fault_hs) <= fault_hs && $past(fault_ls) <= fault_ls));
  p_bst_off_r9: assert property (@(posedge clk) disable iff (!rst_n) bst_uv |=> !hs_gate);
endmodule

bind phase_gate_ctrl phase_gate_chk #(.DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_disable(drv_disable), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
  .bst_uv(bst_uv), .dt_cycles(dt_cycles), .hs_gate(hs_gate), .ls_gate(ls_gate),
  .fault_hs(fault_hs), .fault_ls(fault_ls), .armed_w(armed_w)
);

// File: tb/test_phase_gate_ctrl.sv
module test_phase_gate_ctrl;
  localparam int CLK_P = 10;
  localparam int DT_W  = 10;
  localparam int BL_LONG = 300;
  localparam int BL_SHORT = 273;

  logic clk = 0, rst_n = 0;
  logic drv_disable = 0, hs_cmd = 0, ls_cmd = 0, blank_short = 0;
  logic vds_hs = 0, vds_ls = 0, node_chk_en = 0, sw_node_hi = 1, bst_uv = 0;
  logic [DT_W-1:0] dt_cycles = '0;
  logic hs_gate, ls_gate, fault_hs, fault_ls;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R10";

  // bench model state
  bit m_hs, m_ls, m_fh, m_fl, m_blk, m_cq;
  int m_off, m_hon, m_lon;

  phase_gate_ctrl #(.DT_W(DT_W), .BLANK_LONG(BL_LONG), .BLANK_SHORT(BL_SHORT)) i_phase_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .drv_disable(drv_disable), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
    .dt_cycles(dt_cycles), .blank_short(blank_short), .vds_hs(vds_hs), .vds_ls(vds_ls),
    .node_chk_en(node_chk_en), .sw_node_hi(sw_node_hi), .bst_uv(bst_uv),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .fault_hs(fault_hs), .fault_ls(fault_ls)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int blank_of(input bit s);
    return s ? BL_SHORT : BL_LONG;
  endfunction

  // cycle model written from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_hs = 0; m_ls = 0; m_fh = 0; m_fl = 0; m_blk = 0; m_cq = 0;
      m_off = 0; m_hon = 0; m_lon = 0;
    end else begin
      bit fresh, still_blk, want_h, want_l, quiet;
      fresh     = hs_cmd && !m_cq;
      still_blk = m_blk && !fresh;
      want_h = hs_cmd && !ls_cmd && !drv_disable && !bst_uv && !still_blk;
      want_l = ls_cmd && !hs_cmd && !drv_disable;
      quiet  = !m_hs && !m_ls && (m_off >= int'(dt_cycles));
      if (m_hs && m_hon >= blank_of(blank_short) && (vds_hs || (node_chk_en && !sw_node_hi))) m_fh = 1;
      if (m_ls && m_lon >= blank_of(blank_short) && vds_ls) m_fl = 1;
      m_hon = m_hs ? m_hon + 1 : 0;
      m_lon = m_ls ? m_lon + 1 : 0;
      m_off = (m_hs || m_ls || drv_disable) ? 0 : m_off + 1;
      m_blk = bst_uv || still_blk;
      m_cq  = hs_cmd;
      m_hs  = m_hs ? want_h : (quiet && want_h);
      m_ls  = m_ls ? want_l : (quiet && want_l);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(hs_gate == m_hs, {cur_req, " hs_gate R2"}, hs_gate, m_hs);
    chk(ls_gate == m_ls, {cur_req, " ls_gate R2"}, ls_gate, m_ls);
    chk(fault_hs == m_fh, {cur_req, " fault_hs R7"}, fault_hs, m_fh);
    chk(fault_ls == m_fl, {cur_req, " fault_ls R7"}, fault_ls, m_fl);
  end

  task automatic do_reset(input int dt, input bit shrt);
    @(negedge clk);
    rst_n = 0; hs_cmd = 0; ls_cmd = 0; drv_disable = 0; vds_hs = 0; vds_ls = 0;
    bst_uv = 0; node_chk_en = 0; sw_node_hi = 1;
    dt_cycles = DT_W'(dt); blank_short = shrt;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_gate(input bit hs_side, output int n);
    n = 0;
    while (((hs_side ? hs_gate : ls_gate) == 0) && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("[TB] FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R10 reset state
    do_reset(5, 0);
    cur_req = "R10";
    chk(!hs_gate && !ls_gate && !fault_hs && !fault_ls, "R10 reset outputs", {hs_gate, ls_gate, fault_hs, fault_ls}, 0);

    // R2 handover gap, then R5/R6 long blanking on low side
    cur_req = "R2";
    hs_cmd = 1; wait_gate(1, n);
    hs_cmd = 0; ls_cmd = 1; vds_ls = 1;
    n = 0; @(negedge clk);
    while (!ls_gate && n < 100) begin n++; @(negedge clk); end
    chk(n == 6, "R2 gap cycles", n, 6);
    cur_req = "R5";
    n = 0;
    while (!fault_ls && n < 1000) begin n++; @(negedge clk); end
    chk(n == BL_LONG + 1, "R5 R6 long blanking", n, BL_LONG + 1);
    vds_ls = 0; repeat (5) @(negedge clk);
    chk(fault_ls == 1, "R7 fault sticky", fault_ls, 1);

    // R5 short blanking on high side
    do_reset(3, 1);
    cur_req = "R5";
    hs_cmd = 1; vds_hs = 1; wait_gate(1, n);
    n = 0;
    while (!fault_hs && n < 1000) begin n++; @(negedge clk); end
    chk(n == BL_SHORT + 1, "R5 short blanking", n, BL_SHORT + 1);

    // R8 node check
    do_reset(2, 0);
    cur_req = "R8";
    node_chk_en = 1; hs_cmd = 1; wait_gate(1, n);
    repeat (400) @(negedge clk);
    chk(fault_hs == 0, "R8 node high no fault", fault_hs, 0);
    node_chk_en = 0; sw_node_hi = 0; repeat (3) @(negedge clk);
    chk(fault_hs == 0, "R8 check disabled ignores node", fault_hs, 0);
    node_chk_en = 1; @(negedge clk);
    chk(fault_hs == 1, "R8 node low fault", fault_hs, 1);

    // R1 both commands
    do_reset(1, 0);
    cur_req = "R1";
    hs_cmd = 1; wait_gate(1, n);
    ls_cmd = 1; @(negedge clk);
    chk(!hs_gate && !ls_gate, "R1 both off", {hs_gate, ls_gate}, 0);
    repeat (10) @(negedge clk);
    chk(!hs_gate && !ls_gate, "R1 both stay off", {hs_gate, ls_gate}, 0);

    // R3 disable and restart, R4 turn-off
    ls_cmd = 0; wait_gate(1, n);
    cur_req = "R3";
    drv_disable = 1; @(negedge clk);
    chk(!hs_gate, "R3 disable off", hs_gate, 0);
    repeat (5) @(negedge clk);
    drv_disable = 0; n = 0; @(negedge clk);
    while (!hs_gate && n < 100) begin n++; @(negedge clk); end
    chk(n == 1, "R3 restart dead time", n, 1);
    cur_req = "R4";
    hs_cmd = 0; @(negedge clk);
    chk(!hs_gate, "R4 turn-off next cycle", hs_gate, 0);

    // R9 bootstrap undervoltage
    do_reset(2, 0);
    cur_req = "R9";
    hs_cmd = 1; vds_hs = 1; wait_gate(1, n);
    bst_uv = 1; @(negedge clk); bst_uv = 0;
    chk(!hs_gate, "R9 bst drop", hs_gate, 0);
    repeat (20) @(negedge clk);
    chk(!hs_gate && !fault_hs, "R9 held off no fault", {hs_gate, fault_hs}, 0);
    hs_cmd = 0; @(negedge clk); hs_cmd = 1; @(negedge clk);
    chk(hs_gate == 1, "R9 return on new edge", hs_gate, 1);

    // random segments checked by the model
    for (int seg = 0; seg < 8; seg++) begin
      do_reset($urandom_range(0, 7), 1'($urandom_range(0, 1)));
      cur_req = "R1 R3 R9 random";
      node_chk_en = 1'($urandom_range(0, 1));
      for (int c = 0; c < 1500; c++) begin
        @(negedge clk);
        if ($urandom_range(0, 99) < 3) hs_cmd = ~hs_cmd;
        if ($urandom_range(0, 99) < 3) ls_cmd = ~ls_cmd;
        if ($urandom_range(0, 199) < 2) drv_disable = ~drv_disable;
        bst_uv     = ($urandom_range(0, 99) == 0);
        vds_hs     = ($urandom_range(0, 299) == 0);
        vds_ls     = ($urandom_range(0, 299) == 0);
        sw_node_hi = ($urandom_range(0, 149) != 0);
      end
    end

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule